// File: doc/BRIEF.md
# Cut-off Measurement Line Sequencer

This block schedules the automatic picture-tube cut-off measurement inside the vertical blanking interval of a video control path. A line-rate pulse marks each scan line. At that pulse the block samples a 2-bit code that an upstream slicer derives from the three-level sandcastle signal. It counts lines from the start of vertical blanking. When the blanking interval is long enough, it reserves four fixed lines: one for the summed leakage current and one for each colour gun's cut-off current.

For each of the red, green and blue channels the block drives a 2-bit control: normal video, nominal black, or ultra-black. It also drives four measurement strobes, each high for exactly one line. The strobes tell the analog sensing and gain loops which quantity is being measured on the current line. A field-start strobe abandons any cycle that is in progress.

Top module: `cutoff_seq`

## Requirements
- R1: After a synchronous active-low reset, every channel control is normal (code 00) and all four strobes are low.
- R2: The level code is sampled only in the cycle when `line_pulse` is high; code 01 marks a vertical-blanking line. Codes 00, 10 and 11 mark other lines, and the code is ignored between pulses. From the cycle after the pulse of a vertical-blanking line, every channel shows nominal black (code 01) unless a measurement slot applies.
- R3: The first vertical-blanking line after a non-blanking line, after reset or after a field start is line 1. Each later line pulse adds one.
- R4: A measurement cycle is armed only when at least 4 consecutive vertical-blanking lines occur. A shorter run produces no strobe, and the channels return to normal from the first non-blanking line.
- R5: On line 20 of an armed cycle, strobe bit 0 (leakage) is high and all three channels are ultra-black (code 10).
- R6: On lines 21, 22 and 23 of an armed cycle, strobe bits 1, 2 and 3 go high in turn. The measured channel is at nominal black and the other two are at ultra-black. The channel fields are red in bits [1:0], green in [3:2] and blue in [5:4].
- R7: Once a cycle is armed, the channels stay at least at nominal black up to the end of line 23, even if vertical blanking ends earlier. On a non-blanking line 24 they return to normal.
- R8: The 35th consecutive vertical-blanking line counts as line 1 again and cancels the current cycle. A new cycle then arms on the same rules.
- R9: At most one strobe is high at a time. Outputs change only in the cycle after a line pulse or a field start, so each strobe lasts exactly one line period.
- R10: A field start clears any cycle, so all outputs are normal and strobes are low in the next cycle. It takes priority over a simultaneous line pulse.
- R11: A new rising edge of vertical blanking while an armed cycle is still holding restarts the count at line 1 and drops the pending measurement lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | One-cycle strobe per scan line |
| field_start | input | 1 | One-cycle strobe that abandons the current cycle |
| sc_level | input | 2 | Sliced sandcastle code: 00 none, 01 vertical blank, 10 horizontal blank, 11 burst/clamp |
| chan_mode | output | 6 | Per-channel control: 00 normal, 01 nominal black, 10 ultra-black |
| meas_strobe | output | 4 | Bit 0 leakage, bits 1..3 red, green, blue cut-off |

## Verification
The bench uses blanking runs of 3 and 4 lines to probe the qualification edge. A design that arms one line early would strobe on a 3-line interval; one that arms late would never measure on a 4-line interval. A run of exactly 34 lines and a run of 40 lines check the restart boundary: an off-by-one there would either restart a legal interval or miss the second cycle. Short intervals followed by long non-blanking stretches check that blanking is held to line 23, and a renewed rise during that hold checks that stale measurement lines are dropped. Codes changed between pulses and a field start that coincides with a line pulse expose designs that sample the level continuously or give the line pulse priority.

// File: rtl/cutoff_pkg.sv
package cutoff_pkg;
    typedef enum logic [1:0] {
        SC_NONE   = 2'b00,
        SC_VBLANK = 2'b01,
        SC_HBLANK = 2'b10,
        SC_BURST  = 2'b11
    } sc_code_e;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_BLACK  = 2'b01,
        CH_ULTRA  = 2'b10
    } ch_mode_e;
endpackage

// File: rtl/cutoff_line_counter.sv
module cutoff_line_counter #(
    parameter int CNT_W     = 6,
    parameter int MIN_VB    = 4,
    parameter int MAX_VB    = 34,
    parameter int LEAK_LINE = 20,
    parameter int NUM_CH    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_pulse,
    input  logic             field_start,
    input  logic             is_vb,
    output logic [CNT_W-1:0] cnt_q,
    output logic             armed_q,
    output logic             vb_q
);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_VB);
    localparam logic [CNT_W-1:0] ARM_C  = CNT_W'(MIN_VB - 1);
    localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_VB);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LEAK_LINE + NUM_CH);
    localparam logic [CNT_W-1:0] DONE_C = CNT_W'(LEAK_LINE + NUM_CH + 1);
    localparam logic [CNT_W-1:0] SAT_C  = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             vb;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (field_start) begin
            st_d = '0;
        end else if (line_pulse) begin
            st_d.vb = is_vb;
            if (is_vb && (!st_q.vb || st_q.cnt == MAX_C)) begin
                st_d.cnt   = CNT_W'(1);
                st_d.armed = 1'b0;
            end else begin
                if (st_q.cnt != SAT_C) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (is_vb && st_q.vb && st_q.cnt == ARM_C) begin
                    st_d.armed = 1'b1;
                end
                if (st_d.cnt == DONE_C) begin
                    st_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q   = st_q.cnt;
    assign armed_q = st_q.armed;
    assign vb_q    = st_q.vb;

    // R8: inside a blanking run the count never passes the restart limit
    p_vb_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vb_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= MAX_C));

    // R4: arming happens only on the qualifying blanking line
    p_arm_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> (vb_q && cnt_q == MIN_C));

    // R7: an armed cycle never outlives its last measured line
    p_hold_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (cnt_q >= MIN_C && cnt_q <= LAST_C));

    // R9: state moves only on a line pulse or a field start
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pulse && !field_start) |=> ($stable(cnt_q) && $stable(armed_q) && $stable(vb_q)));

    // R10: field start clears everything
    p_fs_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (cnt_q == '0 && !armed_q && !vb_q));
endmodule

// File: rtl/cutoff_slot_decoder.sv
module cutoff_slot_decoder
    import cutoff_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int LEAK_LINE = 20,
    parameter int NUM_CH    = 3
) (
    input  logic [CNT_W-1:0]    cnt,
    input  logic                armed,
    input  logic                vb,
    output logic [2*NUM_CH-1:0] chan_mode,
    output logic [NUM_CH:0]     strobe
);
    localparam int SLOT_W = $clog2(NUM_CH + 1);
    localparam logic [CNT_W-1:0] LEAK_C = CNT_W'(LEAK_LINE);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LEAK_LINE + NUM_CH);

    logic              in_meas;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        in_meas = armed && (cnt >= LEAK_C) && (cnt <= LAST_C);
        slot    = SLOT_W'(cnt - LEAK_C);
        strobe  = '0;
        if (in_meas) begin
            strobe[slot] = 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_comb begin
            if (in_meas) begin
                chan_mode[2*c +: 2] = (slot == SLOT_W'(c + 1)) ? CH_BLACK : CH_ULTRA;
            end else if (vb || armed) begin
                chan_mode[2*c +: 2] = CH_BLACK;
            end else begin
                chan_mode[2*c +: 2] = CH_NORMAL;
            end
        end
    end
endmodule

// File: rtl/cutoff_seq.sv
module cutoff_seq
    import cutoff_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int MIN_VB    = 4,
    parameter int MAX_VB    = 34,
    parameter int LEAK_LINE = 20,
    parameter int NUM_CH    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_pulse,
    input  logic                field_start,
    input  logic [1:0]          sc_level,
    output logic [2*NUM_CH-1:0] chan_mode,
    output logic [NUM_CH:0]     meas_strobe
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             vb_q;
    logic             is_vb;

    assign is_vb = (sc_level == SC_VBLANK);

    cutoff_line_counter #(
        .CNT_W(CNT_W), .MIN_VB(MIN_VB), .MAX_VB(MAX_VB),
        .LEAK_LINE(LEAK_LINE), .NUM_CH(NUM_CH)
    ) i_counter (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
        .field_start(field_start), .is_vb(is_vb),
        .cnt_q(cnt_q), .armed_q(armed_q), .vb_q(vb_q)
    );

    cutoff_slot_decoder #(
        .CNT_W(CNT_W), .LEAK_LINE(LEAK_LINE), .NUM_CH(NUM_CH)
    ) i_decoder (
        .cnt(cnt_q), .armed(armed_q), .vb(vb_q),
        .chan_mode(chan_mode), .strobe(meas_strobe)
    );

    // R9: strobes are one-hot
    p_onehot_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(meas_strobe));

    // R9: strobes only move after a line pulse or field start
    p_strobe_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(meas_strobe) |-> $past(line_pulse || field_start));

    // R5: leakage line blanks every channel to ultra-black
    p_leak_ultra_r5: assert property (@(posedge clk) disable iff (!rst_n)
        meas_strobe[0] |-> (chan_mode == {NUM_CH{CH_ULTRA}}));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R6: measured channel sits at nominal black
        p_colour_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
            meas_strobe[c+1] |-> (chan_mode[2*c +: 2] == CH_BLACK));
    end
endmodule

// File: tb/test_cutoff_seq.sv
module test_cutoff_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_pulse = 1'b0;
    logic       field_start = 1'b0;
    logic [1:0] sc_level = 2'b00;
    logic [5:0] chan_mode;
    logic [3:0] meas_strobe;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    // bench view of the requirements
    int m_cnt = 0;
    bit m_armed = 0;
    bit m_vb = 0;
    string m_tag = "R1";

    localparam int GAP = 3;

    always #5 clk = ~clk;

    cutoff_seq i_cutoff_seq (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
        .field_start(field_start), .sc_level(sc_level),
        .chan_mode(chan_mode), .meas_strobe(meas_strobe)
    );

    function automatic bit in_meas();
        return m_armed && m_cnt >= 20 && m_cnt <= 23;
    endfunction

    function automatic logic [1:0] exp_mode(int ch);
        if (in_meas()) return (m_cnt - 20 == ch + 1) ? 2'b01 : 2'b10;
        if (m_vb || m_armed) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [3:0] exp_strobe();
        if (in_meas()) return 4'b0001 << (m_cnt - 20);
        return 4'b0000;
    endfunction

    task automatic check(string tag);
        logic [5:0] em;
        logic [3:0] es;
        em = {exp_mode(2), exp_mode(1), exp_mode(0)};
        es = exp_strobe();
        n_chk++;
        if (chan_mode !== em) begin
            n_fail++;
            $display("FAIL %s chan_mode line %0d: got %b expected %b", tag, m_cnt, chan_mode, em);
        end
        n_chk++;
        if (meas_strobe !== es) begin
            n_fail++;
            $display("FAIL %s meas_strobe line %0d: got %b expected %b", tag, m_cnt, meas_strobe, es);
        end
    endtask

    task automatic model_line(bit isvb);
        bit rerise;
        rerise = isvb && !m_vb && m_armed;
        if (isvb && (!m_vb || m_cnt == 34)) begin
            m_tag = (m_vb) ? "R8" : (rerise ? "R11" : "R3");
            m_cnt = 1;
            m_armed = 0;
        end else begin
            if (m_cnt < 63) m_cnt++;
            if (isvb && m_vb && m_cnt == 4) m_armed = 1;
            if (m_cnt == 24) m_armed = 0;
            if (in_meas()) m_tag = (m_cnt == 20) ? "R5" : "R6";
            else if (m_armed && !isvb) m_tag = "R7";
            else if (isvb) m_tag = "R2";
            else m_tag = "R4";
        end
        m_vb = isvb;
    endtask

    function automatic logic [1:0] other_code();
        int r;
        r = $urandom_range(0, 2);
        return (r == 0) ? 2'b00 : ((r == 1) ? 2'b10 : 2'b11);
    endfunction

    task automatic do_line(bit isvb, bit with_fs);
        @(negedge clk);
        sc_level = isvb ? 2'b01 : other_code();
        line_pulse = 1'b1;
        field_start = with_fs;
        if (with_fs) begin
            m_cnt = 0; m_armed = 0; m_vb = 0; m_tag = "R10";
        end else begin
            model_line(isvb);
        end
        @(negedge clk);
        line_pulse = 1'b0;
        field_start = 1'b0;
        check(m_tag);
        for (int g = 0; g < GAP; g++) begin
            // R2: codes between pulses must be ignored, including the blanking code
            sc_level = $urandom_range(0, 3);
            @(negedge clk);
        end
        check("R9");
    endtask

    task automatic do_fs();
        @(negedge clk);
        field_start = 1'b1;
        m_cnt = 0; m_armed = 0; m_vb = 0;
        @(negedge clk);
        field_start = 1'b0;
        check("R10");
    endtask

    task automatic run_field(int vb_len, int tail);
        for (int i = 0; i < vb_len; i++) do_line(1'b1, 1'b0);
        for (int i = 0; i < tail; i++) do_line(1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1");
        // R4: 3-line interval must not arm, 4-line must
        run_field(3, 6);
        run_field(4, 24);
        run_field(22, 6);
        // R8: exactly 34 stays one cycle, 40 restarts
        run_field(34, 4);
        run_field(40, 25);
        // R11: new rise during hold
        run_field(5, 8);
        run_field(6, 24);
        // R10: field start mid cycle and together with a line pulse
        run_field(21, 0);
        do_fs();
        run_field(2, 0);
        do_line(1'b1, 1'b1);
        run_field(25, 3);
        // constrained random intervals
        for (int f = 0; f < 30; f++) begin
            run_field($urandom_range(0, 45), $urandom_range(0, 30));
            if ($urandom_range(0, 9) == 0) do_fs();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule